// File: doc/BRIEF.md
# Table-Switched NCO Quadrature Downconverter

This block shifts a real sample stream down to complex baseband. Each clock it adds the active 32-bit frequency word to a phase register. It looks up cosine and sine for the top phase bits and multiplies the incoming sample by both, which gives an in-phase and a quadrature output sample on every clock. A frequency word of `round(f_out / f_clk * 2^32)` makes the oscillator run at `f_out`, where `f_clk` is the sample clock.

Before operation, software writes a 16-entry frequency table through a simple write port. At run time a select strobe carrying a 4-bit index takes the word held in that entry. The word becomes the active increment after a fixed pipeline delay of a few clocks. Because the strobe is shared by many channels, all of them retune together. A direct-write port can also set the active increment at once, without storing it in the table.

The phase register is never cleared when the increment changes. A retune therefore has no phase step, and reselecting the frequency already in use leaves the output untouched.

Top module: `nco_ddc`

## Requirements
- R1: While `rst` is high, and at the first clock after it falls, the outputs, the phase and the active word are zero, all table entries are zero and no select is pending.
- R2: A clock edge with `tab_wr_en` high stores `tab_wr_word` in entry `tab_wr_addr` (0 to 15). A table write alone never changes the active word or the outputs.
- R3: At each edge the phase becomes the old phase plus the active word, modulo 2^32. The lookup index k is the top 10 phase bits. The sine value for k is the nearest integer to 32767·sin(2πk/1024), and the cosine value for k is the sine value at index (k+256) mod 1024.
- R4: Each edge registers `i_out = (x·cos + 2^14) >>> 15` and `q_out = (x·sin + 2^14) >>> 15`. These use the sample x present before the edge and the phase held before the edge.
- R5: A `sel_stb` sampled at edge E reads the entry `sel_idx` as it stood before E, ignoring any write in the same cycle. That word becomes the active word at edge E+4 (SEL_LAT=4). The active word changes at no other time, except through a direct write.
- R6: A reload replaces only the increment and never touches the phase. Selecting a word equal to the active one leaves the outputs identical to an uninterrupted run.
- R7: A `dir_stb` at edge E makes `dir_word` the active word at E, with no change to any table entry. A later select replaces it.
- R8: If a select reaches its apply edge in the same edge as a direct write, the selected word wins and the direct word is discarded.
- R9: A table write after a strobe does not alter the word already in flight. Strobes on consecutive clocks are each applied, in order, one clock apart.
- R10: A zero input sample gives zero on both outputs in the next cycle. A full-scale input of -32768 gives outputs that stay within the 16-bit signed range, as the rounding in R4 implies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| tab_wr_en | input | 1 | Frequency table write enable |
| tab_wr_addr | input | 4 | Table entry to write |
| tab_wr_word | input | 32 | Frequency word to store |
| sel_stb | input | 1 | Select strobe |
| sel_idx | input | 4 | Table entry to select |
| dir_stb | input | 1 | Direct write strobe for the active word |
| dir_word | input | 32 | Word for a direct write |
| smp_in | input | 16 | Real input sample, signed |
| i_out | output | 16 | In-phase product, signed |
| q_out | output | 16 | Quadrature product, signed |

## Verification
A select that reaches its apply edge can meet a direct write in the same clock. The bench provokes this by issuing a direct write exactly four clocks after a strobe, and it expects the table word to win. A second collision happens when a table write lands in the cycle of the strobe that reads the same entry, or in the cycle after it. The bench judges both cases by comparing the I/Q outputs, on every clock, against a behavioural model whose phase would diverge from the design after any wrong choice.

// File: rtl/nco_ddc_pkg.sv
package nco_ddc_pkg;
    parameter int FREQ_BITS = 32;
    parameter int SMP_BITS  = 16;

    typedef struct packed {
        logic                 vld;
        logic [FREQ_BITS-1:0] word;
    } sel_slot_t;

    typedef struct packed {
        logic [FREQ_BITS-1:0]       freq;
        logic [FREQ_BITS-1:0]       phase;
        logic signed [SMP_BITS-1:0] i;
        logic signed [SMP_BITS-1:0] q;
    } ddc_state_t;
endpackage

// File: rtl/nco_freq_table.sv
module nco_freq_table
    import nco_ddc_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int AW      = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [FREQ_BITS-1:0] wr_word,
    input  logic [AW-1:0]        rd_addr,
    output logic [FREQ_BITS-1:0] rd_word
);
    logic [FREQ_BITS-1:0] tab_d [ENTRIES];
    logic [FREQ_BITS-1:0] tab_q [ENTRIES];

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) tab_d[e] = tab_q[e];
        if (wr_en) tab_d[wr_addr] = wr_word;
    end

    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (rst) tab_q[e] <= '0;
            else     tab_q[e] <= tab_d[e];
        end
    end

    assign rd_word = tab_q[rd_addr];
endmodule

// File: rtl/nco_sel_pipe.sv
module nco_sel_pipe
    import nco_ddc_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_stb,
    input  logic [FREQ_BITS-1:0] in_word,
    output logic                 out_vld,
    output logic [FREQ_BITS-1:0] out_word
);
    sel_slot_t pipe_d [LAT];
    sel_slot_t pipe_q [LAT];

    always_comb begin
        pipe_d[0] = '{vld: in_stb, word: in_word};
        for (int s = 1; s < LAT; s++) pipe_d[s] = pipe_q[s-1];
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < LAT; s++) begin
            if (rst) pipe_q[s] <= '0;
            else     pipe_q[s] <= pipe_d[s];
        end
    end

    assign out_vld  = pipe_q[LAT-1].vld;
    assign out_word = pipe_q[LAT-1].word;
endmodule

// File: rtl/nco_sincos_rom.sv
module nco_sincos_rom
    import nco_ddc_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic [AW-1:0]              idx,
    output logic signed [SMP_BITS-1:0] sin_o,
    output logic signed [SMP_BITS-1:0] cos_o
);
    localparam int  DEPTH = 1 << AW;
    localparam int  QTR   = DEPTH / 4;
    localparam real TWOPI = 6.28318530717958647692;
    localparam real AMP   = real'((1 << (SMP_BITS-1)) - 1);

    function automatic int nearest(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(0.5 - v);
    endfunction

    logic signed [SMP_BITS-1:0] lut [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_lut
        localparam int VAL = nearest(AMP * $sin(TWOPI * real'(k) / real'(DEPTH)));
        assign lut[k] = SMP_BITS'(VAL);
    end

    logic [AW-1:0] cos_idx;
    assign cos_idx = idx + AW'(QTR);
    assign sin_o   = lut[idx];
    assign cos_o   = lut[cos_idx];
endmodule

// File: rtl/nco_ddc.sv
module nco_ddc
    import nco_ddc_pkg::*;
#(
    parameter int TAB_ENTRIES = 16,
    parameter int LUT_AW      = 10,
    parameter int SEL_LAT     = 4,
    localparam int TAB_AW     = $clog2(TAB_ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tab_wr_en,
    input  logic [TAB_AW-1:0]          tab_wr_addr,
    input  logic [FREQ_BITS-1:0]       tab_wr_word,
    input  logic                       sel_stb,
    input  logic [TAB_AW-1:0]          sel_idx,
    input  logic                       dir_stb,
    input  logic [FREQ_BITS-1:0]       dir_word,
    input  logic signed [SMP_BITS-1:0] smp_in,
    output logic signed [SMP_BITS-1:0] i_out,
    output logic signed [SMP_BITS-1:0] q_out
);
    localparam int PROD_W = 2 * SMP_BITS;
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (SMP_BITS-2);

    ddc_state_t st_d, st_q;

    logic [FREQ_BITS-1:0]       sel_word;
    logic                       apply_vld;
    logic [FREQ_BITS-1:0]       apply_word;
    logic signed [SMP_BITS-1:0] sin_v, cos_v;
    logic signed [PROD_W-1:0]   prod_i, prod_q;

    nco_freq_table #(.ENTRIES(TAB_ENTRIES)) u_tab (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tab_wr_en),
        .wr_addr (tab_wr_addr),
        .wr_word (tab_wr_word),
        .rd_addr (sel_idx),
        .rd_word (sel_word)
    );

    nco_sel_pipe #(.LAT(SEL_LAT)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .in_stb   (sel_stb),
        .in_word  (sel_word),
        .out_vld  (apply_vld),
        .out_word (apply_word)
    );

    nco_sincos_rom #(.AW(LUT_AW)) u_rom (
        .idx   (st_q.phase[FREQ_BITS-1 -: LUT_AW]),
        .sin_o (sin_v),
        .cos_o (cos_v)
    );

    assign prod_i = smp_in * cos_v;
    assign prod_q = smp_in * sin_v;

    always_comb begin
        st_d       = st_q;
        st_d.phase = st_q.phase + st_q.freq;
        if (apply_vld)    st_d.freq = apply_word;
        else if (dir_stb) st_d.freq = dir_word;
        st_d.i = SMP_BITS'((prod_i + HALF) >>> (SMP_BITS-1));
        st_d.q = SMP_BITS'((prod_q + HALF) >>> (SMP_BITS-1));
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign i_out = st_q.i;
    assign q_out = st_q.q;
endmodule

// File: rtl/nco_ddc_chk.sv
module nco_ddc_chk
    import nco_ddc_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       dir_stb,
    input logic [FREQ_BITS-1:0]       dir_word,
    input logic signed [SMP_BITS-1:0] smp_in,
    input logic signed [SMP_BITS-1:0] i_out,
    input logic signed [SMP_BITS-1:0] q_out,
    input ddc_state_t                 st,
    input logic                       apply_vld,
    input logic [FREQ_BITS-1:0]       apply_word
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (st.freq == '0 && st.phase == '0 && i_out == '0 && q_out == '0)); // R1

    AST_FREQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(apply_vld) && !$past(dir_stb)) |-> $stable(st.freq)); // R5

    AST_DIR_LOADS: assert property (@(posedge clk) disable iff (rst)
        ($past(dir_stb) && !$past(apply_vld)) |-> st.freq == $past(dir_word)); // R7

    AST_SEL_WINS: assert property (@(posedge clk) disable iff (rst)
        $past(apply_vld) |-> st.freq == $past(apply_word)); // R8

    AST_PHASE_CARRIES: assert property (@(posedge clk) disable iff (rst)
        $past(apply_vld) |-> st.phase == $past(st.phase) + $past(st.freq)); // R6

    AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
        ($past(smp_in) == '0) |-> (i_out == '0 && q_out == '0)); // R10
endmodule

bind nco_ddc nco_ddc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .dir_stb    (dir_stb),
    .dir_word   (dir_word),
    .smp_in     (smp_in),
    .i_out      (i_out),
    .q_out      (q_out),
    .st         (st_q),
    .apply_vld  (apply_vld),
    .apply_word (apply_word)
);

// File: tb/sim_nco_ddc.sv
module sim_nco_ddc;
    localparam int LAT = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst = 1'b1;
    logic               tab_wr_en = 1'b0;
    logic [3:0]         tab_wr_addr = '0;
    logic [31:0]        tab_wr_word = '0;
    logic               sel_stb = 1'b0;
    logic [3:0]         sel_idx = '0;
    logic               dir_stb = 1'b0;
    logic [31:0]        dir_word = '0;
    logic signed [15:0] smp_in = '0;
    logic signed [15:0] i_out, q_out;

    nco_ddc #(.SEL_LAT(LAT)) u0 (
        .clk(clk), .rst(rst), .tab_wr_en(tab_wr_en), .tab_wr_addr(tab_wr_addr),
        .tab_wr_word(tab_wr_word), .sel_stb(sel_stb), .sel_idx(sel_idx),
        .dir_stb(dir_stb), .dir_word(dir_word), .smp_in(smp_in),
        .i_out(i_out), .q_out(q_out)
    );

    int    n_vec = 0, n_bad = 0;
    bit    finished = 0;
    string req = "R1";

    int                 lut [1024];
    logic [31:0]        m_tab [16];
    logic [31:0]        m_freq, m_phase;
    logic               m_pv [LAT];
    logic [31:0]        m_pw [LAT];
    logic signed [15:0] m_i, m_q;
    logic [15:0]        lfsr = 16'hACE1;
    bit                 auto_x = 1;

    function automatic int nearest(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(0.5 - v);
    endfunction

    function automatic logic signed [15:0] mix(input logic signed [15:0] x, input int c);
        longint p;
        p = longint'(x) * longint'(c);
        p = (p + 64'sd16384) >>> 15;
        return p[15:0];
    endfunction

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic model_reset();
        for (int e = 0; e < 16; e++) m_tab[e] = '0;
        for (int s = 0; s < LAT; s++) begin m_pv[s] = 0; m_pw[s] = '0; end
        m_freq = '0; m_phase = '0; m_i = '0; m_q = '0;
    endtask

    // one clock: inputs already set by caller at the negedge
    task automatic step();
        int k;
        logic [31:0] nf;
        if (auto_x) begin
            lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            smp_in = lfsr;
        end
        k   = int'(m_phase[31:22]);
        m_i = mix(smp_in, lut[(k + 256) % 1024]);
        m_q = mix(smp_in, lut[k]);
        if (m_pv[LAT-1])  nf = m_pw[LAT-1];
        else if (dir_stb) nf = dir_word;
        else              nf = m_freq;
        for (int s = LAT-1; s > 0; s--) begin m_pv[s] = m_pv[s-1]; m_pw[s] = m_pw[s-1]; end
        m_pv[0] = sel_stb;
        m_pw[0] = m_tab[sel_idx];
        if (tab_wr_en) m_tab[tab_wr_addr] = tab_wr_word;
        m_phase = m_phase + m_freq;
        m_freq  = nf;
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (i_out !== m_i || q_out !== m_q) begin
            n_bad++;
            $display("FAIL %s: i=%0d q=%0d expected i=%0d q=%0d", req, i_out, q_out, m_i, m_q);
        end
        sel_stb = 0; dir_stb = 0; tab_wr_en = 0;
    endtask

    task automatic run(input int n);
        for (int c = 0; c < n; c++) step();
    endtask

    task automatic do_sel(input int idx);
        sel_stb = 1; sel_idx = 4'(idx);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        report();
    end

    initial begin
        for (int k = 0; k < 1024; k++)
            lut[k] = nearest(32767.0 * $sin(6.28318530717958647692 * real'(k) / 1024.0));
        model_reset();
        smp_in = 16'sd1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs held at zero while in reset
        req = "R1";
        n_vec++;
        if (i_out !== 16'sd0 || q_out !== 16'sd0) begin
            n_bad++;
            $display("FAIL R1: i=%0d q=%0d expected i=0 q=0", i_out, q_out);
        end
        rst = 0;
        run(8);

        // R2: fill the table, outputs must not move (active word stays 0)
        req = "R2";
        for (int e = 0; e < 16; e++) begin
            tab_wr_en = 1; tab_wr_addr = 4'(e);
            tab_wr_word = (e == 0) ? 32'h0 : (e == 15) ? 32'h8000_0000 :
                          (e == 14) ? 32'hFFFF_FFFF : 32'h0123_4567 * (e + 3);
            step();
        end
        run(4);

        // R5: select latency
        req = "R5";
        do_sel(3); step();
        run(12);
        // R3: steady accumulation and lookup
        req = "R3";
        run(40);
        // R4: rounding over a ramp of inputs
        req = "R4";
        auto_x = 0;
        for (int v = -8; v < 8; v++) begin smp_in = 16'(v * 4099); step(); end
        auto_x = 1;

        // R6: reselect the same word, phase continues
        req = "R6";
        do_sel(3); step();
        run(20);

        // R7: direct write, then a select overwrites it
        req = "R7";
        dir_stb = 1; dir_word = 32'h1357_9BDF; step();
        run(10);
        do_sel(7); step();
        run(10);

        // R8: direct write lands on the apply edge of a select
        req = "R8";
        do_sel(2); step();
        run(LAT - 1);
        dir_stb = 1; dir_word = 32'h0F0F_0F0F; step();
        run(10);

        // R9: table write right after strobe, and back-to-back strobes
        req = "R9";
        do_sel(4); step();
        tab_wr_en = 1; tab_wr_addr = 4'd4; tab_wr_word = 32'h2222_0000; step();
        run(8);
        do_sel(8); tab_wr_en = 1; tab_wr_addr = 4'd8; tab_wr_word = 32'h0444_4444; step();
        do_sel(9); step();
        do_sel(10); step();
        do_sel(4); step();
        run(12);

        // R10: zero and full-scale negative inputs
        req = "R10";
        auto_x = 0;
        smp_in = 16'sd0; run(10);
        do_sel(15); step();
        smp_in = -16'sd32768; run(12);
        do_sel(14); step();
        run(12);
        auto_x = 1;
        run(10);

        report();
    end
endmodule